// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a table of power-up commands, one slot at a time, and plays them onto a DDR2 command bus (chip select, row strobe, column strobe, write enable, bank and address). Each slot carries a valid flag, a command kind, a bank (which also selects the mode register for mode-register writes), an address or mode-register value, and a wait count in memory clocks. The wait count sets the gap to the next command. Usually the table holds the standard DDR2 bring-up order: a NOP, precharge-all, writes to the four mode registers with a DLL reset, a second precharge, four refreshes, a mode write that clears DLL reset, and an extended-mode write that enters and then leaves the default off-chip-driver calibration.

A one-cycle start pulse launches the table. Slots whose valid flag is clear are passed over without a bus cycle. A busy flag covers the whole run. A done flag rises once the last valid slot's wait has run out. Between commands the bus idles with chip select high. After completion, a controller-enable request is accepted. A memory-ready flag follows once the delay-line calibration flag is also seen.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, chip select, row strobe, column strobe and write enable are all high, and busy, done, controller-enable and memory-ready are all low.
- R2: Slot s occupies bits [s*27 +: 27] of the table input. Its fields are wait [7:0], address [21:8], bank [23:22], command [25:24] and valid [26]. A start pulse seen while idle raises busy at the next edge and clears done, controller-enable and memory-ready.
- R3: Valid slots are issued in ascending slot index, each exactly once per run.
- R4: The first valid slot is issued one cycle after busy rises. Each later command comes W cycles after the one before, where W is the previous slot's wait count and a count of 0 acts as 1.
- R5: A slot with valid clear produces no bus command and adds no cycles.
- R6: Command codes map to row/column/write-enable strobes as follows: 0 NOP = HHH, 1 precharge = LHL, 2 refresh = LLH, 3 mode-register set = LLL. Chip select is low only in an issue cycle.
- R7: In an issue cycle the bank and address pins carry the slot's fields, except that a precharge also drives address bit 10 high (all banks). In every cycle with chip select high, the three strobes are high.
- R8: Busy falls and done rises W cycles after the last valid command, where W is that slot's wait (0 acts as 1). When no slot is valid, this happens one cycle after busy rises.
- R9: A start pulse that arrives while busy is ignored, and the run continues unchanged.
- R10: Controller-enable rises one cycle after an edge at which done and the enable request are both high. A request made before done is refused.
- R11: Memory-ready rises one cycle after an edge at which controller-enable and the delay-line calibration flag are both high. It stays low while the calibration flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Launch the command table |
| slotTable | input | 378 | 14 slot words of 27 bits, slot 0 lowest |
| ctrlEnReq | input | 1 | Request to enable the controller |
| dlCalDone | input | 1 | Delay-line calibration complete |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank / mode-register select |
| addr | output | 14 | Address / mode value |
| initBusy | output | 1 | Sequence running |
| initDone | output | 1 | Sequence complete |
| ctrlEnable | output | 1 | Controller enabled |
| memReady | output | 1 | Controller enabled and calibration seen |

## Verification
Two events can land on the same edge: the end of the last slot's wait, which raises done, and a pending controller-enable request. The bench holds the request high through the whole run so that it is present at exactly that edge. It expects controller-enable to stay low in the cycle where done first reads high and to rise one cycle later. A second collision is a start pulse in the middle of a run. The bench judges it by requiring the command order and spacing to match an undisturbed run exactly.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } initCmd_e;

  typedef struct packed {
    logic issue;
    logic restart;
  } seqStrobe_t;
endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int NUM_SLOTS = 14,
  parameter int WAIT_W    = 8,
  parameter int PTR_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startPulse,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*WAIT_W-1:0] slotWaitFlat,
  input  logic                        ctrlEnReq,
  input  logic                        dlCalDone,
  output seqStrobe_t                  strobe,
  output logic [PTR_W-1:0]            pickIdx,
  output logic                        initBusy,
  output logic                        initDone,
  output logic                        ctrlEnable,
  output logic                        memReady
);
  localparam int PAD = 2 ** PTR_W;

  logic [WAIT_W-1:0] waitArr [PAD];
  logic [PAD-1:0]    validPad;

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    if (i < NUM_SLOTS) begin : g_real
      assign waitArr[i]  = slotWaitFlat[i*WAIT_W +: WAIT_W];
      assign validPad[i] = slotValid[i];
    end else begin : g_fill
      assign waitArr[i]  = '0;
      assign validPad[i] = 1'b0;
    end
  end

  logic [PTR_W-1:0]  ptr;
  logic [WAIT_W-1:0] cnt;
  logic              found;
  logic              advance;
  logic              startAcc;
  logic [WAIT_W-1:0] pickWait;

  // first valid slot at or after the pointer
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int i = PAD - 1; i >= 0; i--) begin
      if (validPad[i] && (PTR_W'(i) >= ptr)) begin
        found   = 1'b1;
        pickIdx = PTR_W'(i);
      end
    end
  end

  assign pickWait       = (waitArr[pickIdx] == '0) ? WAIT_W'(1) : waitArr[pickIdx];
  assign startAcc       = startPulse && !initBusy;
  assign advance        = initBusy && (cnt == WAIT_W'(1));
  assign strobe.issue   = advance && found;
  assign strobe.restart = startAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initBusy <= 1'b0;
      initDone <= 1'b0;
      ptr      <= '0;
      cnt      <= WAIT_W'(1);
    end else if (startAcc) begin
      initBusy <= 1'b1;
      initDone <= 1'b0;
      ptr      <= '0;
      cnt      <= WAIT_W'(1);
    end else if (initBusy) begin
      if (advance) begin
        if (found) begin
          ptr <= pickIdx + PTR_W'(1);
          cnt <= pickWait;
        end else begin
          initBusy <= 1'b0;
          initDone <= 1'b1;
        end
      end else begin
        cnt <= cnt - WAIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || startAcc) begin
      ctrlEnable <= 1'b0;
    end else if (initDone && ctrlEnReq) begin
      ctrlEnable <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || startAcc) begin
      memReady <= 1'b0;
    end else if (ctrlEnable && dlCalDone) begin
      memReady <= 1'b1;
    end
  end

  a_r8_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(initBusy && initDone));
  a_r4_wait_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    initBusy |-> (cnt != '0));
  a_r10_enable_after_done: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnable |-> initDone);
  a_r11_ready_after_enable: assert property (@(posedge clk) disable iff (!rstN)
    memReady |-> ctrlEnable);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (initBusy && startPulse && !advance) |=> initBusy);
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !initBusy) |=> (initBusy && !initDone));
endmodule

// File: rtl/ddr2_init_dpath.sv
module ddr2_init_dpath
  import ddr2_init_pkg::*;
#(
  parameter int NUM_SLOTS = 14,
  parameter int ADDR_W    = 14,
  parameter int PTR_W     = $clog2(NUM_SLOTS + 1),
  parameter int FIELD_W   = ADDR_W + 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic [PTR_W-1:0]             pickIdx,
  input  logic [NUM_SLOTS*FIELD_W-1:0] slotFieldFlat,
  output logic                         csN,
  output logic                         rasN,
  output logic                         casN,
  output logic                         weN,
  output logic [1:0]                   ba,
  output logic [ADDR_W-1:0]            addr
);
  localparam int PAD     = 2 ** PTR_W;
  localparam int A10_BIT = 10;

  logic [FIELD_W-1:0] fieldArr [PAD];

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    if (i < NUM_SLOTS) begin : g_real
      assign fieldArr[i] = slotFieldFlat[i*FIELD_W +: FIELD_W];
    end else begin : g_fill
      assign fieldArr[i] = '0;
    end
  end

  logic [FIELD_W-1:0] selField;
  initCmd_e           selCmd;
  logic [2:0]         strobeBits;
  logic [ADDR_W-1:0]  selAddr;

  assign selField = fieldArr[pickIdx];
  assign selCmd   = initCmd_e'(selField[FIELD_W-1 -: 2]);

  always_comb begin
    selAddr = selField[ADDR_W-1:0];
    unique case (selCmd)
      CMD_NOP: strobeBits = 3'b111;
      CMD_PRE: begin
        strobeBits       = 3'b010;
        selAddr[A10_BIT] = 1'b1;
      end
      CMD_REF: strobeBits = 3'b001;
      CMD_MRS: strobeBits = 3'b000;
      default: strobeBits = 3'b111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart || !strobe.issue) begin
      csN  <= 1'b1;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      ba   <= '0;
      addr <= '0;
    end else begin
      csN                <= 1'b0;
      {rasN, casN, weN}  <= strobeBits;
      ba                 <= selField[ADDR_W +: 2];
      addr               <= selAddr;
    end
  end

  a_r7_idle_is_nop: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (rasN && casN && weN));
  a_r7_precharge_all_banks: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN) |-> addr[A10_BIT]);
  a_r6_select_follows_issue: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> !csN);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int NUM_SLOTS = 14,
  parameter int WAIT_W    = 8,
  parameter int ADDR_W    = 14,
  parameter int SLOT_W    = WAIT_W + ADDR_W + 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startPulse,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slotTable,
  input  logic                        ctrlEnReq,
  input  logic                        dlCalDone,
  output logic                        csN,
  output logic                        rasN,
  output logic                        casN,
  output logic                        weN,
  output logic [1:0]                  ba,
  output logic [ADDR_W-1:0]           addr,
  output logic                        initBusy,
  output logic                        initDone,
  output logic                        ctrlEnable,
  output logic                        memReady
);
  localparam int PTR_W   = $clog2(NUM_SLOTS + 1);
  localparam int FIELD_W = ADDR_W + 4;

  logic [NUM_SLOTS-1:0]         slotValid;
  logic [NUM_SLOTS*WAIT_W-1:0]  slotWaitFlat;
  logic [NUM_SLOTS*FIELD_W-1:0] slotFieldFlat;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_split
    assign slotValid[s]                        = slotTable[s*SLOT_W + SLOT_W - 1];
    assign slotWaitFlat[s*WAIT_W +: WAIT_W]    = slotTable[s*SLOT_W +: WAIT_W];
    assign slotFieldFlat[s*FIELD_W +: FIELD_W] = slotTable[s*SLOT_W + WAIT_W +: FIELD_W];
  end

  seqStrobe_t       strobe;
  logic [PTR_W-1:0] pickIdx;

  ddr2_init_ctrl #(.NUM_SLOTS(NUM_SLOTS), .WAIT_W(WAIT_W), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .slotValid(slotValid), .slotWaitFlat(slotWaitFlat),
    .ctrlEnReq(ctrlEnReq), .dlCalDone(dlCalDone),
    .strobe(strobe), .pickIdx(pickIdx),
    .initBusy(initBusy), .initDone(initDone),
    .ctrlEnable(ctrlEnable), .memReady(memReady)
  );

  ddr2_init_dpath #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
                    .FIELD_W(FIELD_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pickIdx(pickIdx),
    .slotFieldFlat(slotFieldFlat),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr)
  );
endmodule

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;
  localparam int NS = 14;
  localparam int SW = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic ctrlEnReq = 1'b0;
  logic dlCalDone = 1'b0;
  logic [NS*SW-1:0] slotTable = '0;
  logic csN, rasN, casN, weN, initBusy, initDone, ctrlEnable, memReady;
  logic [1:0] ba;
  logic [13:0] addr;

  int checks = 0;
  int errors = 0;

  bit       tEn   [NS];
  int       tCmd  [NS];
  int       tBa   [NS];
  int       tAddr [NS];
  int       tWait [NS];

  always #4ns clk = ~clk;

  ddr2_init_seq dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .slotTable(slotTable),
    .ctrlEnReq(ctrlEnReq), .dlCalDone(dlCalDone),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .initBusy(initBusy), .initDone(initDone),
    .ctrlEnable(ctrlEnable), .memReady(memReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic packTable();
    for (int s = 0; s < NS; s++) begin
      slotTable[s*SW +: SW] = {tEn[s], 2'(tCmd[s]), 2'(tBa[s]), 14'(tAddr[s]), 8'(tWait[s])};
    end
  endtask

  function automatic int pinsOf(input int cmd);
    case (cmd)
      0: return 7;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic loadDefault();
    int mrBase  = 14'h0042;
    int emrBase = 14'h0044;
    int cmds[NS]  = '{0, 1, 3, 3, 3, 3, 1, 2, 2, 2, 2, 3, 3, 3};
    int banks[NS] = '{0, 0, 2, 3, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    int waits[NS] = '{106, 4, 2, 2, 2, 200, 4, 25, 25, 25, 25, 2, 2, 2};
    int addrs[NS];
    addrs = '{0, 0, 0, 0, emrBase, mrBase | 14'h0100, 0, 0, 0, 0, 0, mrBase,
              emrBase | 14'h0380, emrBase};
    for (int s = 0; s < NS; s++) begin
      tEn[s] = 1'b1; tCmd[s] = cmds[s]; tBa[s] = banks[s];
      tAddr[s] = addrs[s]; tWait[s] = waits[s];
    end
  endtask

  task automatic runSeq(input bit reqHeld, input bit midStart, input string tag);
    int expT[NS]; int expS[NS]; int nExp = 0; int tE = 1;
    int gotT[16]; int gotP[16]; int gotBa[16]; int gotA[16]; int nGot = 0;
    int tDoneSeen = -1; bit earlyEn = 1'b0; bit badIdle = 1'b0;
    packTable();
    for (int s = 0; s < NS; s++) begin
      if (tEn[s]) begin
        expT[nExp] = tE; expS[nExp] = s; nExp++;
        tE += (tWait[s] == 0) ? 1 : tWait[s];
      end
    end
    ctrlEnReq = reqHeld; dlCalDone = 1'b0; startPulse = 1'b1;
    @(posedge clk); @(negedge clk); startPulse = 1'b0;
    check(initBusy == 1'b1, {"R2 busy after start ", tag}, initBusy, 1);
    check(!initDone && !ctrlEnable && !memReady, {"R2 flags cleared ", tag},
          {initDone, ctrlEnable, memReady}, 0);
    for (int t = 0; t <= tE + 2; t++) begin
      if (t > 0) @(negedge clk);
      if (!csN) begin
        if (nGot < 16) begin
          gotT[nGot] = t; gotP[nGot] = {rasN, casN, weN}; gotBa[nGot] = ba; gotA[nGot] = addr;
        end
        nGot++;
      end else if (!(rasN && casN && weN)) badIdle = 1'b1;
      if (initDone && tDoneSeen < 0) tDoneSeen = t;
      if (ctrlEnable && t <= tE) earlyEn = 1'b1;
      if (reqHeld && t == tE) check(ctrlEnable == 1'b0, {"R10 same-cycle refuse ", tag}, ctrlEnable, 0);
      if (reqHeld && t == tE + 1) check(ctrlEnable == 1'b1, {"R10 enable after done ", tag}, ctrlEnable, 1);
      startPulse = midStart && (t == 3);
    end
    startPulse = 1'b0;
    check(!badIdle, {"R7 idle bus is NOP ", tag}, badIdle, 0);
    check(nGot == nExp, {"R3 R5 command count ", tag}, nGot, nExp);
    for (int k = 0; k < nExp && k < nGot; k++) begin
      int s = expS[k];
      int ea = (tCmd[s] == 1) ? (tAddr[s] | 14'h0400) : tAddr[s];
      check(gotT[k] == expT[k], {"R4 R5 issue cycle ", tag}, gotT[k], expT[k]);
      check(gotP[k] == pinsOf(tCmd[s]), {"R3 R6 strobes ", tag}, gotP[k], pinsOf(tCmd[s]));
      check(gotBa[k] == tBa[s] && gotA[k] == ea, {"R7 bank/address ", tag},
            gotBa[k] * 65536 + gotA[k], tBa[s] * 65536 + ea);
    end
    check(tDoneSeen == tE, {"R8 done timing ", tag}, tDoneSeen, tE);
    check(!initBusy, {"R8 busy cleared ", tag}, initBusy, 0);
    check(!earlyEn, {"R10 no enable before done ", tag}, earlyEn, 0);
    if (!reqHeld) begin
      check(!ctrlEnable, {"R10 no request no enable ", tag}, ctrlEnable, 0);
      ctrlEnReq = 1'b1;
      @(negedge clk);
      check(ctrlEnable, {"R10 enable on request ", tag}, ctrlEnable, 1);
    end
    check(!memReady, {"R11 ready waits for calibration ", tag}, memReady, 0);
    dlCalDone = 1'b1;
    @(negedge clk);
    check(memReady, {"R11 ready after calibration ", tag}, memReady, 1);
    dlCalDone = 1'b0; ctrlEnReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN && rasN && casN && weN, "R1 bus idle at reset", {csN, rasN, casN, weN}, 15);
    check(!initBusy && !initDone && !ctrlEnable && !memReady, "R1 status at reset",
          {initBusy, initDone, ctrlEnable, memReady}, 0);
    rstN = 1'b1;
    @(negedge clk);

    loadDefault();
    runSeq(1'b1, 1'b0, "default");

    loadDefault();
    tEn[0] = 1'b0; tEn[6] = 1'b0; tEn[13] = 1'b0;
    runSeq(1'b0, 1'b1, "masked+midstart R9");

    for (int s = 0; s < NS; s++) begin
      tEn[s] = 1'b1; tCmd[s] = s % 4; tBa[s] = (s * 3) % 4;
      tAddr[s] = (s * 1237) % 16384; tWait[s] = s % 4;
    end
    runSeq(1'b1, 1'b0, "short waits");

    for (int s = 0; s < NS; s++) tEn[s] = (s % 2 == 1);
    for (int s = 0; s < NS; s++) tWait[s] = 1;
    runSeq(1'b0, 1'b0, "alternate R5");

    for (int s = 0; s < NS; s++) tEn[s] = 1'b0;
    runSeq(1'b1, 1'b0, "empty table");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule